// File: doc/BRIEF.md
# NAND Bad Block Scan Engine

This engine builds a bad-block table for a NAND array in hardware. A start pulse makes it walk every block in increasing order. For each block it reads one marker byte from each of the block's first two pages. That byte is the first spare-area byte, at column 2048. The block counts as good only when both bytes read FFh. The result for each block goes into a 1024-bit map held inside the engine.

The engine reaches the device through a simple bus-cycle request port. Each request is a command write, an address write or a data read. A separate controller turns each request into the real NAND strobes. The engine uses only the page-read command pair and never programs or erases. It also watches the device ready line. When the scan ends, firmware reads the map one bit at a time through a read port. It also gets the number of good blocks, a flag that is set when that number falls below the device minimum, and a sticky flag that is set when the device stayed busy for too long.

Top module: `nand_bbscan`

## Requirements
- R1: A `start` pulse while the engine is idle clears the map, the good count, `done` and `timeout_err`, raises `busy` on the next cycle, and begins with block 0.
- R2: Each page read is issued as this exact series of transfers: a command of 00h, four address bytes, then a command of 30h. The four address bytes are 00h, 08h, row[7:0] and row[15:8], where row = block*64 + page. Page 0 is read before page 1, and the blocks run from 0 up to 1023.
- R3: After 30h the engine ignores `nand_rdy` for a settle period. It then waits for `nand_rdy` high and makes exactly one data-read transfer for that page, only after it has seen `nand_rdy` high.
- R4: A block's map bit is 0 (good) only if both marker bytes equal FFh. Any other value sets the bit to 1 (bad).
- R5: If `nand_rdy` stays low for TIMEOUT_CYC cycles of waiting, the engine skips the data read, marks the block bad and sets `timeout_err`. That flag is cleared only by reset or by a new start.
- R6: `good_count` holds the number of blocks with map bit 0. `below_min` is high only while `done` is high and `good_count` is less than 1004. A count of exactly 1004 does not raise it.
- R7: `done` rises once block 1023 has been recorded. In that same cycle the count and the map are already final, and they stay unchanged until the next start.
- R8: The only command bytes ever issued are 00h and 30h.
- R9: Transfer encoding: `cyc_kind` is 0 for a command, 1 for an address and 2 for a data read. A request stays asserted, with its kind and byte unchanged, until `cyc_ack`. The read byte is taken from `cyc_rdata` in the acknowledge cycle.
- R10: `bm_bad` shows the map bit selected by `bm_addr` one clock after the address is applied.
- R11: While `rst_n` is low at a clock edge, the engine goes idle: no request, `done`, `busy` and `timeout_err` low, count 0, map cleared.
- R12: A `start` pulse during a scan is ignored. The scan continues and its results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle scan start pulse |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, results valid |
| good_count | output | 11 | Number of good blocks |
| below_min | output | 1 | Good count under 1004 (valid with done) |
| timeout_err | output | 1 | Sticky: ready wait expired |
| bm_addr | input | 10 | Map read block index |
| bm_bad | output | 1 | Map bit for bm_addr, 1 = bad, one cycle later |
| cyc_req | output | 1 | Bus transfer request |
| cyc_kind | output | 2 | 0 command, 1 address, 2 data read |
| cyc_wdata | output | 8 | Command or address byte |
| cyc_ack | input | 1 | Transfer accepted / read data valid |
| cyc_rdata | input | 8 | Byte returned by a data read |
| nand_rdy | input | 1 | Device ready line, high = ready |

## Verification
Most wrong internal states in this engine show up as wrong address bytes. A block counter or page bit that drifts produces a row that does not match the expected block*64+page at the very next 30h command, so a bench model of the device catches it within one page read. A wrong accumulation of the marker results shows up only at the end, in `good_count` and in the map walk. For that reason the patterns put bad markers on page 0 of some blocks, on page 1 of others, and on the last block, and some scans land exactly on the 1004 threshold. Errors in the timer or in the ready handshake show up as a data read issued while the device is busy, or as a missing or extra read in the same page.

// File: rtl/nbs_pkg.sv
// Shared encodings for the bad-block scan engine: bus transfer kinds,
// command bytes and the sequencer state type.
package nbs_pkg;
    typedef enum logic [1:0] {
        CYC_CMD   = 2'd0,
        CYC_ADDR  = 2'd1,
        CYC_RDATA = 2'd2
    } cyc_kind_t;

    localparam logic [7:0] OP_RD_SETUP = 8'h00;
    localparam logic [7:0] OP_RD_GO    = 8'h30;
    localparam logic [7:0] MARK_GOOD   = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_SETUP,
        ST_ADDR,
        ST_CMD_GO,
        ST_SETTLE,
        ST_WAIT,
        ST_FETCH,
        ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/nbs_seq.sv
// Scan sequencer. It walks blocks 0..NUM_BLOCKS-1 and pages 0 and 1 of each,
// issues one read-command series per page, waits on the ready line with a
// timeout, fetches one marker byte and reports a per-block verdict.
// Assumes SETTLE_CYC >= 1 and TIMEOUT_CYC >= 1.
module nbs_seq
    import nbs_pkg::*;
#(
    parameter int NUM_BLOCKS      = 1024,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int SPARE_COL       = 2048,
    parameter int SETTLE_CYC      = 4,
    parameter int TIMEOUT_CYC     = 100000,
    localparam int BLK_W          = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cyc_ack,
    input  logic [7:0]       cyc_rdata,
    input  logic             nand_rdy,
    output logic             cyc_req,
    output logic [1:0]       cyc_kind,
    output logic [7:0]       cyc_wdata,
    output logic             busy,
    output logic             done,
    output logic             tmo_err,
    output logic             clr,
    output logic             fin,
    output logic [BLK_W-1:0] fin_blk,
    output logic             fin_bad
);
    localparam int TMR_W = $clog2(TIMEOUT_CYC + SETTLE_CYC + 1);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
    localparam logic [15:0] COL = 16'(SPARE_COL);

    seq_state_t       st_q;
    logic [BLK_W-1:0] blk_q;
    logic             page_q;
    logic [1:0]       step_q;
    logic [TMR_W-1:0] tmr_q;
    logic             bad_acc_q;
    logic [15:0]      row;
    logic             expired;
    logic             page_end;
    logic             page_bad;

    // Row address of the page being read.
    assign row = 16'(blk_q) * 16'(PAGES_PER_BLOCK) + 16'(page_q);

    // Wait expiry and end-of-page detection.
    always_comb begin
        expired  = (st_q == ST_WAIT) && !nand_rdy && (tmr_q == TMR_W'(TIMEOUT_CYC - 1));
        page_end = ((st_q == ST_FETCH) && cyc_ack) || expired;
        page_bad = ((st_q == ST_FETCH) && (cyc_rdata != MARK_GOOD)) || expired;
    end

    // Drive the bus request from the current state.
    always_comb begin
        cyc_req   = 1'b0;
        cyc_kind  = CYC_CMD;
        cyc_wdata = 8'h00;
        unique case (st_q)
            ST_CMD_SETUP: begin
                cyc_req   = 1'b1;
                cyc_wdata = OP_RD_SETUP;
            end
            ST_ADDR: begin
                cyc_req  = 1'b1;
                cyc_kind = CYC_ADDR;
                unique case (step_q)
                    2'd0: cyc_wdata = COL[7:0];
                    2'd1: cyc_wdata = COL[15:8];
                    2'd2: cyc_wdata = row[7:0];
                    default: cyc_wdata = row[15:8];
                endcase
            end
            ST_CMD_GO: begin
                cyc_req   = 1'b1;
                cyc_wdata = OP_RD_GO;
            end
            ST_FETCH: begin
                cyc_req  = 1'b1;
                cyc_kind = CYC_RDATA;
            end
            default: ;
        endcase
    end

    assign busy = (st_q != ST_IDLE);

    // State, position, timer and verdict registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            blk_q     <= '0;
            page_q    <= 1'b0;
            step_q    <= 2'd0;
            tmr_q     <= '0;
            bad_acc_q <= 1'b0;
            done      <= 1'b0;
            tmo_err   <= 1'b0;
            clr       <= 1'b0;
            fin       <= 1'b0;
            fin_blk   <= '0;
            fin_bad   <= 1'b0;
        end else begin
            clr <= 1'b0;
            fin <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (start) begin
                    clr       <= 1'b1;
                    done      <= 1'b0;
                    tmo_err   <= 1'b0;
                    blk_q     <= '0;
                    page_q    <= 1'b0;
                    bad_acc_q <= 1'b0;
                    st_q      <= ST_CMD_SETUP;
                end
                ST_CMD_SETUP: if (cyc_ack) begin
                    step_q <= 2'd0;
                    st_q   <= ST_ADDR;
                end
                ST_ADDR: if (cyc_ack) begin
                    if (step_q == 2'd3) st_q <= ST_CMD_GO;
                    else                step_q <= step_q + 2'd1;
                end
                ST_CMD_GO: if (cyc_ack) begin
                    tmr_q <= '0;
                    st_q  <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (tmr_q == TMR_W'(SETTLE_CYC - 1)) begin
                        tmr_q <= '0;
                        st_q  <= ST_WAIT;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (nand_rdy)     st_q    <= ST_FETCH;
                    else if (expired) tmo_err <= 1'b1;
                    else              tmr_q   <= tmr_q + 1'b1;
                end
                ST_FINISH: begin
                    done <= 1'b1;
                    st_q <= ST_IDLE;
                end
                default: ;
            endcase
            if (page_end) begin
                if (page_q) begin
                    fin       <= 1'b1;
                    fin_blk   <= blk_q;
                    fin_bad   <= bad_acc_q | page_bad;
                    bad_acc_q <= 1'b0;
                    page_q    <= 1'b0;
                    if (blk_q == LAST_BLK) begin
                        st_q <= ST_FINISH;
                    end else begin
                        blk_q <= blk_q + 1'b1;
                        st_q  <= ST_CMD_SETUP;
                    end
                end else begin
                    page_q    <= 1'b1;
                    bad_acc_q <= bad_acc_q | page_bad;
                    st_q      <= ST_CMD_SETUP;
                end
            end
        end
    end
endmodule

// File: rtl/nbs_bitmap.sv
// Per-block bad map: one flop per block, cleared by clr, written by the
// sequencer verdict, read through a registered one-cycle port.
// Assumes NUM_BLOCKS is a power of two so every read address is in range.
module nbs_bitmap #(
    parameter int NUM_BLOCKS = 1024,
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic             wr_bad,
    input  logic [BLK_W-1:0] rd_addr,
    output logic             rd_bad
);
    logic [NUM_BLOCKS-1:0] map_q;

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_bit
        // One map bit: cleared on reset or start, loaded by its block's verdict.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                       map_q[g] <= 1'b0;
            else if (wr && (wr_blk == BLK_W'(g)))    map_q[g] <= wr_bad;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_bad <= 1'b0;
        else        rd_bad <= map_q[rd_addr];
    end
endmodule

// File: rtl/nbs_tally.sv
// Good-block counter and minimum-count flag.
// Assumes that fin pulses once per block and that done is held after the scan.
module nbs_tally #(
    parameter int NUM_BLOCKS = 1024,
    parameter int MIN_GOOD   = 1004,
    localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fin,
    input  logic             fin_bad,
    input  logic             done,
    output logic [CNT_W-1:0] good_count,
    output logic             below_min
);
    // Count the good verdicts of the current scan.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       good_count <= '0;
        else if (fin && !fin_bad) good_count <= good_count + 1'b1;
    end

    // The minimum flag is valid only once the scan is done.
    assign below_min = done && (good_count < CNT_W'(MIN_GOOD));
endmodule

// File: rtl/nand_bbscan.sv
// Top of the bad-block scan engine: sequencer, map and tally.
// Assumes an external controller turns each request into NAND strobes and
// acknowledges it, and that nand_rdy is synchronous to clk.
module nand_bbscan #(
    parameter int NUM_BLOCKS      = 1024,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int SPARE_COL       = 2048,
    parameter int MIN_GOOD        = 1004,
    parameter int SETTLE_CYC      = 4,
    parameter int TIMEOUT_CYC     = 100000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    output logic                              busy,
    output logic                              done,
    output logic [$clog2(NUM_BLOCKS+1)-1:0]   good_count,
    output logic                              below_min,
    output logic                              timeout_err,
    input  logic [$clog2(NUM_BLOCKS)-1:0]     bm_addr,
    output logic                              bm_bad,
    output logic                              cyc_req,
    output logic [1:0]                        cyc_kind,
    output logic [7:0]                        cyc_wdata,
    input  logic                              cyc_ack,
    input  logic [7:0]                        cyc_rdata,
    input  logic                              nand_rdy
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);

    logic             clr;
    logic             fin;
    logic [BLK_W-1:0] fin_blk;
    logic             fin_bad;

    nbs_seq #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
        .SPARE_COL(SPARE_COL), .SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cyc_ack(cyc_ack),
        .cyc_rdata(cyc_rdata), .nand_rdy(nand_rdy), .cyc_req(cyc_req),
        .cyc_kind(cyc_kind), .cyc_wdata(cyc_wdata), .busy(busy), .done(done),
        .tmo_err(timeout_err), .clr(clr), .fin(fin), .fin_blk(fin_blk),
        .fin_bad(fin_bad)
    );

    nbs_bitmap #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr(fin), .wr_blk(fin_blk),
        .wr_bad(fin_bad), .rd_addr(bm_addr), .rd_bad(bm_bad)
    );

    nbs_tally #(.NUM_BLOCKS(NUM_BLOCKS), .MIN_GOOD(MIN_GOOD)) u_tally (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fin(fin), .fin_bad(fin_bad),
        .done(done), .good_count(good_count), .below_min(below_min)
    );
endmodule

// File: rtl/nand_bbscan_chk.sv
// Port-level protocol and result checks for nand_bbscan, bound to every instance.
module nand_bbscan_chk #(
    parameter int NUM_BLOCKS = 1024
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            start,
    input logic                            busy,
    input logic                            done,
    input logic [$clog2(NUM_BLOCKS+1)-1:0] good_count,
    input logic                            below_min,
    input logic                            timeout_err,
    input logic                            cyc_req,
    input logic [1:0]                      cyc_kind,
    input logic [7:0]                      cyc_wdata,
    input logic                            cyc_ack,
    input logic                            nand_rdy
);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_req && !cyc_ack |=> cyc_req && $stable(cyc_kind) && $stable(cyc_wdata));

    // R8
    cmd_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_req && cyc_kind == 2'd0 |-> cyc_wdata == 8'h00 || cyc_wdata == 8'h30);

    // R3
    read_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_req) && cyc_kind == 2'd2 |-> $past(nand_rdy));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !cyc_req);

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> $stable(good_count));

    // R5
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err && !(start && !busy) |=> timeout_err);

    // R1
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && !done && !timeout_err);

    // R6
    below_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        below_min |-> done && good_count <= ($clog2(NUM_BLOCKS+1))'(NUM_BLOCKS));
endmodule

bind nand_bbscan nand_bbscan_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (.*);

// File: tb/sim_nand_bbscan.sv
module sim_nand_bbscan;
    localparam int NB  = 1024;
    localparam int TMO = 24;
    // Scan table: pattern, expected good count, expected below_min, expected timeout_err
    localparam int SCAN_TBL [3][4] = '{'{0, 1010, 0, 0}, '{1, 996, 1, 1}, '{2, 1004, 0, 0}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, below_min, timeout_err, bm_bad;
    logic [10:0] good_count;
    logic [9:0]  bm_addr = '0;
    logic        cyc_req, cyc_ack;
    logic [1:0]  cyc_kind;
    logic [7:0]  cyc_wdata;
    logic [7:0]  cyc_rdata = 8'hFF;
    logic        nand_rdy = 1'b1;

    always #2 clk = ~clk;

    nand_bbscan #(.SETTLE_CYC(2), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .good_count(good_count), .below_min(below_min), .timeout_err(timeout_err),
        .bm_addr(bm_addr), .bm_bad(bm_bad), .cyc_req(cyc_req), .cyc_kind(cyc_kind),
        .cyc_wdata(cyc_wdata), .cyc_ack(cyc_ack), .cyc_rdata(cyc_rdata),
        .nand_rdy(nand_rdy)
    );

    assign cyc_ack = cyc_req;

    int total = 0, bad = 0;
    bit finished = 0;
    int pat = 0;

    function automatic logic [7:0] marker(int p, int b, int pg);
        if (p == 0) begin
            if (pg == 0 && b % 128 == 3) return 8'h00;
            if (pg == 1 && b % 200 == 50) return 8'h7F;
            if (pg == 1 && b == 1023) return 8'hFE;
        end else if (p == 1) begin
            if (pg == 0 && b % 64 == 3) return 8'h00;
            if (pg == 1 && b % 100 == 50) return 8'h80;
        end else begin
            if (b < 20 && pg == (b % 2)) return (pg == 0) ? 8'h00 : 8'hEF;
        end
        return 8'hFF;
    endfunction

    function automatic bit hang(int p, int b, int pg);
        return p == 1 && ((b == 10 && pg == 0) || (b == 1023 && pg == 1));
    endfunction

    function automatic bit exp_bad(int p, int b);
        return marker(p, b, 0) != 8'hFF || marker(p, b, 1) != 8'hFF || hang(p, b, 0) || hang(p, b, 1);
    endfunction

    // Device model state
    int pos = 0, exp_blk = 0, exp_pg = 0, pages = 0;
    int proto_err = 0, cmd_err = 0, rd_err = 0, rd_cnt = 0, busy_left = 0;
    int cur_blk = 0, cur_pg = 0;
    bit hold = 0;
    logic [7:0] a [4];

    // Device model: protocol tracking, ready line and marker data
    always @(negedge clk) begin
        if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) nand_rdy <= 1'b1;
        end
        if (cyc_req) begin
            case (cyc_kind)
                2'd0: begin
                    if (cyc_wdata == 8'h00) begin
                        pos = 0;
                        if (hold) begin hold = 0; nand_rdy <= 1'b1; end
                    end else if (cyc_wdata == 8'h30) begin
                        // R2: address series and row order
                        if (pos != 4 || a[0] != 8'h00 || a[1] != 8'h08 ||
                            {a[3], a[2]} != 16'(exp_blk * 64 + exp_pg)) proto_err++;
                        cur_blk = int'({a[3], a[2]}) / 64;
                        cur_pg  = int'({a[3], a[2]}) % 64;
                        pages++;
                        rd_cnt = 0;
                        nand_rdy <= 1'b0;
                        if (hang(pat, cur_blk, cur_pg)) hold = 1;
                        else busy_left = 3;
                        exp_pg = 1 - exp_pg;
                        if (exp_pg == 0) exp_blk++;
                    end else begin
                        cmd_err++;
                    end
                end
                2'd1: begin
                    if (pos < 4) a[pos] = cyc_wdata;
                    pos++;
                end
                default: begin
                    if (!nand_rdy || rd_cnt != 0) rd_err++;
                    rd_cnt++;
                    cyc_rdata <= marker(pat, cur_blk, cur_pg);
                end
            endcase
        end
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        pos = 0; exp_blk = 0; exp_pg = 0; pages = 0;
        proto_err = 0; cmd_err = 0; rd_err = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    initial begin
        bit ok;
        int mism;
        int ebits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 busy after reset", busy, 0);
        chk("R11 done after reset", done, 0);
        chk("R11 req after reset", cyc_req, 0);
        chk("R11 count after reset", good_count, 0);
        chk("R11 timeout after reset", timeout_err, 0);
        bm_addr = 10'd5;
        @(negedge clk);
        chk("R11 map after reset", bm_bad, 0);

        for (int s = 0; s < 3; s++) begin
            pat = SCAN_TBL[s][0];
            model_clear();
            pulse_start();
            // R1: busy raised, done and timeout cleared
            chk("R1 busy after start", busy, 1);
            chk("R1 done cleared", done, 0);
            chk("R1 timeout cleared", timeout_err, 0);
            if (s == 0) begin
                repeat (500) @(negedge clk);
                pulse_start(); // R12: ignored mid-scan
            end
            wait_done(ok);
            chk("R7 scan reached done", ok, 1);
            chk("R6 good count", good_count, SCAN_TBL[s][1]);
            chk("R6 below_min", below_min, SCAN_TBL[s][2]);
            chk("R5 timeout flag", timeout_err, SCAN_TBL[s][3]);
            chk("R2 address series errors", proto_err, 0);
            chk("R12 R2 pages read", pages, 2 * NB);
            chk("R8 foreign command bytes", cmd_err, 0);
            chk("R3 reads while busy or repeated", rd_err, 0);
            // R4 R10: walk the map with one-cycle read latency
            mism = 0;
            ebits = 0;
            for (int b = 0; b < NB; b++) begin
                bm_addr = 10'(b);
                @(negedge clk);
                if (bm_bad != exp_bad(pat, b)) mism++;
                if (exp_bad(pat, b)) ebits++;
            end
            chk("R4 R10 map mismatches", mism, 0);
            chk("R4 expected bad bits vs count", NB - ebits, good_count);
            chk("R7 done held", done, 1);
        end

        // R11: reset in the middle of a scan
        pat = 0;
        model_clear();
        pulse_start();
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 busy after mid-scan reset", busy, 0);
        chk("R11 req after mid-scan reset", cyc_req, 0);
        chk("R11 count after mid-scan reset", good_count, 0);
        chk("R11 done after mid-scan reset", done, 0);
        rst_n = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            summary();
            $finish;
        end
    end
endmodule